// File: doc/BRIEF.md
# Masked Control Register File

This block holds the internal 64-bit control registers of a processor core behind a single indexed port. One index addresses both the read and the write side. The read data follows the index combinationally, and a write takes effect on the next rising clock edge. Each index carries its own write rule. A register may keep every bit, keep only the bits of a fixed mask, return to zero on any write, accept exactly one write, be writable but not readable, or be readable but not writable.

One register is a cycle-counter view. Its readback joins the upper half that software last wrote with the low 32 bits of a counter that runs freely from reset. Writes that translation buffers act on do not change a table here. They raise a one-cycle strobe, and the translation logic consumes it. A speculation input discards writes completely. An illegal access sets a sticky error flag, captures the offending index, and changes nothing.

Top module: `ctlreg_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every register clears, except three. Index 32 (trap base) loads the parameter `BASE_RESET`, index 33 (misc control) loads 0x6, and scratch index 16 loads `cpu_id` zero-extended. After that edge `err` and `side_fx` are 0.
- R2: Indices 0 to 23 (scratch), 32, 33, 34 (perf control), 53, 54 (cache parity status) and 80 (data PTE staging) keep all 64 written bits. Their value appears on `rd_data` combinationally from `idx` after the write edge.
- R3: Writes keep only the masked bits at these indices. Masks 0xF: 38 and 39. Mask 0x18: 40 and 41. Mask 0xFF_FFFF_0300: 45. Mask 0xFFFF_FFFF_C000_0000: 46 and 47. Mask 0x1FFB: 48. Mask 0x3F: 49 and 50. Mask 0x7F0: 51. Mask 0xFE00_0000_0000_0000: 52. Mask 0x1F: 55. Mask 0x7FFF0: 56.
- R4: A write to index 37 (exception PC) stores the data with bit 1 forced to 0.
- R5: Indices 43 and 44 (exception summary and mask) read 0 after any write, whatever the data.
- R6: Reading index 35 returns the upper 32 written bits above the low 32 bits of a counter. The counter is 0 while `rst` is high and adds 1 at every later clock edge.
- R7: Index 36 (cycle-counter control) is write-only. The first write after reset is accepted and sets it to 1. A further write while it is nonzero is an error.
- R8: These accesses are errors: reading a write-only index (36, 42, 70 to 73, 81, 82, 84 to 89), writing a read-only index (60 to 64, which always read 0), and reading or writing any other undefined index (24 to 31, 57 to 59, 65 to 69, 74 to 79, 83, 90 to 127).
- R9: When `spec` is high with `wr_en`, the write is dropped completely. No register changes, no error is raised, and no strobe fires.
- R10: The first error sets `err` and latches `idx` into `err_idx` one edge later. Both hold until reset. An errored access changes no register and fires no strobe.
- R11: An accepted write raises exactly one `side_fx` bit for the single cycle after the write edge. The bits are: bit 0 for index 81 (data tag insert), bit 1 for 82 (instruction PTE insert), bit 2 for 84 (data flush all), bit 3 for 85 (data flush process), bit 4 for 86 (data flush address), bit 5 for 87 (instruction flush all), bit 6 for 88 (instruction flush process), and bit 7 for 89 (instruction flush address). Other writes raise none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_id | input | 8 | Core number loaded into scratch 16 at reset |
| idx | input | 7 | Register index for read and write |
| rd_en | input | 1 | Read access is being made (for error checking) |
| wr_en | input | 1 | Write strobe |
| spec | input | 1 | Speculative path; suppresses writes |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Combinational read data for `idx` |
| err | output | 1 | Sticky illegal-access flag |
| err_idx | output | 7 | Index of the first illegal access |
| side_fx | output | 8 | One-cycle translation-buffer strobes |

## Verification
A wrong mask or write rule inside the block becomes visible on `rd_data` as soon as the written index is read, which is one cycle after the write. The exception is the write-only registers. Their state shows only indirectly: through `err` on the second cycle-counter control write, or through `side_fx` in the cycle right after the write edge. A miscounted cycle counter shows as a wrong difference between two reads of index 35 taken a known number of edges apart. A misclassified index sets `err` and `err_idx` one edge after the access, and the wrong value persists until reset.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int XLEN = 64;
  localparam int HALF = XLEN / 2;
  localparam int FX_N = 8;

  // index map
  localparam int IX_TRAP_BASE = 32;
  localparam int IX_MISC      = 33;
  localparam int IX_PERF      = 34;
  localparam int IX_CYC       = 35;
  localparam int IX_CYC_CTL   = 36;
  localparam int IX_EXC_PC    = 37;
  localparam int IX_AST_REQ   = 38;
  localparam int IX_AST_EN    = 39;
  localparam int IX_MODE_I    = 40;
  localparam int IX_MODE_D    = 41;
  localparam int IX_MODE_ALT  = 42;
  localparam int IX_EXC_SUM   = 43;
  localparam int IX_EXC_MSK   = 44;
  localparam int IX_INSN_CTL  = 45;
  localparam int IX_VPT_I     = 46;
  localparam int IX_VPT_D     = 47;
  localparam int IX_DC_TEST   = 48;
  localparam int IX_DC_MODE   = 49;
  localparam int IX_MAF_MODE  = 50;
  localparam int IX_ASN_I     = 51;
  localparam int IX_ASN_D     = 52;
  localparam int IX_IC_PERR   = 53;
  localparam int IX_DC_PERR   = 54;
  localparam int IX_INT_LVL   = 55;
  localparam int IX_SW_INT    = 56;
  localparam int IX_RO_FIRST  = 60;
  localparam int IX_RO_LAST   = 64;
  localparam int IX_WO_FIRST  = 70;
  localparam int IX_WO_LAST   = 73;
  localparam int IX_DPTE      = 80;
  localparam int IX_DTAG      = 81;
  localparam int IX_IPTE      = 82;
  localparam int IX_DFL_ALL   = 84;
  localparam int IX_DFL_PROC  = 85;
  localparam int IX_DFL_ADDR  = 86;
  localparam int IX_IFL_ALL   = 87;
  localparam int IX_IFL_PROC  = 88;
  localparam int IX_IFL_ADDR  = 89;
  localparam int IX_TOP       = 89;

  // strobe bit positions
  localparam int FX_DINS   = 0;
  localparam int FX_IINS   = 1;
  localparam int FX_DALL   = 2;
  localparam int FX_DPROC  = 3;
  localparam int FX_DADDR  = 4;
  localparam int FX_IALL   = 5;
  localparam int FX_IPROC  = 6;
  localparam int FX_IADDR  = 7;

  typedef struct packed {
    logic            rd_ok;
    logic            wr_ok;
    logic            stored;
    logic            clr;
    logic            once;
    logic            cyc;
    logic [FX_N-1:0] fx;
    logic [XLEN-1:0] mask;
  } attr_t;

  function automatic attr_t mk_rw(input logic [XLEN-1:0] m);
    attr_t a;
    a        = '0;
    a.rd_ok  = 1'b1;
    a.wr_ok  = 1'b1;
    a.stored = 1'b1;
    a.mask   = m;
    return a;
  endfunction

  function automatic attr_t mk_ro();
    attr_t a;
    a       = '0;
    a.rd_ok = 1'b1;
    return a;
  endfunction

  function automatic attr_t mk_wo(input int fx_bit);
    attr_t a;
    a       = '0;
    a.wr_ok = 1'b1;
    if (fx_bit >= 0) a.fx[fx_bit] = 1'b1;
    return a;
  endfunction
endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
  import ctlreg_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int SCR_N = 24
) (
  input  logic [IDX_W-1:0] idx,
  output attr_t            attr
);
  localparam logic [XLEN-1:0] ALL = '1;
  int unsigned ix;

  always_comb begin
    ix   = 32'(idx);
    attr = '0;
    if (ix < SCR_N) begin
      attr = mk_rw(ALL);
    end else begin
      case (ix)
        IX_TRAP_BASE, IX_MISC, IX_PERF,
        IX_IC_PERR, IX_DC_PERR, IX_DPTE: attr = mk_rw(ALL);
        IX_CYC: begin
          attr     = mk_rw(ALL);
          attr.cyc = 1'b1;
        end
        IX_CYC_CTL: begin
          attr        = mk_wo(-1);
          attr.stored = 1'b1;
          attr.once   = 1'b1;
        end
        IX_EXC_PC:              attr = mk_rw(~64'h2);
        IX_AST_REQ, IX_AST_EN:  attr = mk_rw(64'hF);
        IX_MODE_I, IX_MODE_D:   attr = mk_rw(64'h18);
        IX_MODE_ALT:            attr = mk_wo(-1);
        IX_EXC_SUM, IX_EXC_MSK: begin
          attr     = mk_rw(ALL);
          attr.clr = 1'b1;
        end
        IX_INSN_CTL:            attr = mk_rw(64'h0000_00FF_FFFF_0300);
        IX_VPT_I, IX_VPT_D:     attr = mk_rw(64'hFFFF_FFFF_C000_0000);
        IX_DC_TEST:             attr = mk_rw(64'h1FFB);
        IX_DC_MODE, IX_MAF_MODE: attr = mk_rw(64'h3F);
        IX_ASN_I:               attr = mk_rw(64'h7F0);
        IX_ASN_D:               attr = mk_rw(64'hFE00_0000_0000_0000);
        IX_INT_LVL:             attr = mk_rw(64'h1F);
        IX_SW_INT:              attr = mk_rw(64'h7FFF0);
        IX_DTAG:                attr = mk_wo(FX_DINS);
        IX_IPTE:                attr = mk_wo(FX_IINS);
        IX_DFL_ALL:             attr = mk_wo(FX_DALL);
        IX_DFL_PROC:            attr = mk_wo(FX_DPROC);
        IX_DFL_ADDR:            attr = mk_wo(FX_DADDR);
        IX_IFL_ALL:             attr = mk_wo(FX_IALL);
        IX_IFL_PROC:            attr = mk_wo(FX_IPROC);
        IX_IFL_ADDR:            attr = mk_wo(FX_IADDR);
        default: begin
          if (ix >= IX_RO_FIRST && ix <= IX_RO_LAST)      attr = mk_ro();
          else if (ix >= IX_WO_FIRST && ix <= IX_WO_LAST) attr = mk_wo(-1);
          else                                            attr = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ctlreg_store.sv
module ctlreg_store
  import ctlreg_pkg::*;
#(
  parameter int              IDX_W      = 7,
  parameter int              CPU_W      = 8,
  parameter int              CPU_SLOT   = 16,
  parameter logic [XLEN-1:0] BASE_RESET = 64'h0000_0000_0000_8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CPU_W-1:0] cpu_id,
  input  logic             we,
  input  logic [IDX_W-1:0] addr,
  input  logic [XLEN-1:0]  wval,
  output logic [XLEN-1:0]  rval
);
  localparam int DEPTH = 1 << IDX_W;

  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      mem[IX_TRAP_BASE] <= BASE_RESET;
      mem[IX_MISC]      <= 64'h6;
      mem[CPU_SLOT]     <= XLEN'(cpu_id);
    end else if (we) begin
      mem[addr] <= wval;
    end
  end

  assign rval = mem[addr];
endmodule

// File: rtl/ctlreg_cycle.sv
module ctlreg_cycle #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/ctlreg_err.sv
module ctlreg_err #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bad,
  input  logic [IDX_W-1:0] idx,
  output logic             err,
  output logic [IDX_W-1:0] err_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err     <= 1'b0;
      err_idx <= '0;
    end else if (bad && !err) begin
      err     <= 1'b1;
      err_idx <= idx;
    end
  end

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  // R10
  err_idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> $stable(err_idx));
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int              IDX_W      = 7,
  parameter int              CPU_W      = 8,
  parameter int              SCR_N      = 24,
  parameter int              CPU_SLOT   = 16,
  parameter logic [63:0]     BASE_RESET = 64'h0000_0000_0000_8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CPU_W-1:0] cpu_id,
  input  logic [IDX_W-1:0] idx,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic             spec,
  input  logic [63:0]      wr_data,
  output logic [63:0]      rd_data,
  output logic             err,
  output logic [IDX_W-1:0] err_idx,
  output logic [7:0]       side_fx
);
  attr_t           attr;
  logic [XLEN-1:0] rval;
  logic [HALF-1:0] cyc_cnt;
  logic            wr_req, wr_bad, rd_bad, any_bad, we;
  logic [XLEN-1:0] wval;

  ctlreg_decode #(.IDX_W(IDX_W), .SCR_N(SCR_N)) u_dec (
    .idx(idx), .attr(attr));

  ctlreg_store #(.IDX_W(IDX_W), .CPU_W(CPU_W), .CPU_SLOT(CPU_SLOT),
                 .BASE_RESET(BASE_RESET)) u_mem (
    .clk(clk), .rst(rst), .cpu_id(cpu_id), .we(we), .addr(idx),
    .wval(wval), .rval(rval));

  ctlreg_cycle #(.CNT_W(HALF)) u_cyc (
    .clk(clk), .rst(rst), .count(cyc_cnt));

  always_comb begin
    wr_req  = wr_en && !spec;
    wr_bad  = wr_req && (!attr.wr_ok || (attr.once && (rval != '0)));
    rd_bad  = rd_en && !attr.rd_ok;
    any_bad = wr_bad || rd_bad;
    we      = wr_req && !any_bad && attr.stored;
    if (attr.once)     wval = XLEN'(1);
    else if (attr.clr) wval = '0;
    else               wval = wr_data & attr.mask;
  end

  always_comb begin
    if (!attr.rd_ok)   rd_data = '0;
    else if (attr.cyc) rd_data = {rval[XLEN-1:HALF], cyc_cnt};
    else               rd_data = rval;
  end

  ctlreg_err #(.IDX_W(IDX_W)) u_err (
    .clk(clk), .rst(rst), .bad(any_bad), .idx(idx),
    .err(err), .err_idx(err_idx));

  always_ff @(posedge clk) begin
    if (rst)                      side_fx <= '0;
    else if (wr_req && !any_bad)  side_fx <= attr.fx;
    else                          side_fx <= '0;
  end

  // R9
  spec_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && spec) |=> (side_fx == '0));
  // R4
  exc_pc_bit1_chk: assert property (@(posedge clk) disable iff (rst)
    (idx == IDX_W'(IX_EXC_PC)) |-> !rd_data[1]);
  // R3
  mode_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ((idx == IDX_W'(IX_MODE_I)) || (idx == IDX_W'(IX_MODE_D)))
      |-> ((rd_data & ~64'h18) == '0));
  // R8
  bad_read_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !attr.rd_ok) |=> err);
  // R11
  fx_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(side_fx));
endmodule

// File: tb/sim_ctlreg_bank.sv
module sim_ctlreg_bank;
  localparam logic [63:0] BASE = 64'h0000_0000_0000_8000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cpu_id = 8'h5A;
  logic [6:0]  idx = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0, spec = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        err;
  logic [6:0]  err_idx;
  logic [7:0]  side_fx;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [63:0] model [128];
  logic [7:0]  fx_seen;

  always #4 clk = ~clk;

  ctlreg_bank u0 (
    .clk(clk), .rst(rst), .cpu_id(cpu_id), .idx(idx), .rd_en(rd_en),
    .wr_en(wr_en), .spec(spec), .wr_data(wr_data), .rd_data(rd_data),
    .err(err), .err_idx(err_idx), .side_fx(side_fx));

  function automatic logic [63:0] exp_wr(input int i, input logic [63:0] d);
    case (i)
      37:      return d & ~64'h2;
      38, 39:  return d & 64'hF;
      40, 41:  return d & 64'h18;
      43, 44:  return 64'h0;
      45:      return d & 64'h0000_00FF_FFFF_0300;
      46, 47:  return d & 64'hFFFF_FFFF_C000_0000;
      48:      return d & 64'h1FFB;
      49, 50:  return d & 64'h3F;
      51:      return d & 64'h7F0;
      52:      return d & 64'hFE00_0000_0000_0000;
      55:      return d & 64'h1F;
      56:      return d & 64'h7FFF0;
      default: return d;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [63:0] d, input bit s);
    @(negedge clk);
    idx = 7'(i); wr_data = d; wr_en = 1'b1; spec = s;
    @(negedge clk);
    wr_en = 1'b0; spec = 1'b0;
    fx_seen = side_fx;
  endtask

  task automatic rd(input int i, output logic [63:0] v);
    @(negedge clk);
    idx = 7'(i); rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_reset(input logic [7:0] cid);
    @(negedge clk);
    rst = 1'b1; cpu_id = cid; idx = 7'd35; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(rd_data == 64'h0, "R6 counter zero at reset", rd_data, 64'h0);
    check(err == 1'b0 && side_fx == 8'h0, "R1 err/fx cleared",
          {err, side_fx}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, a, b, d;
    int rwl[45];
    int extra[21] = '{32,33,34,37,38,39,40,41,45,46,47,48,49,50,51,52,53,54,55,56,80};
    int fxi[8] = '{81,82,84,85,86,87,88,89};
    void'($urandom(32'h1234_5EED));
    for (int k = 0; k < 24; k++) rwl[k] = k;
    for (int k = 0; k < 21; k++) rwl[24 + k] = extra[k];
    for (int k = 0; k < 128; k++) model[k] = 64'h0;
    model[32] = BASE; model[33] = 64'h6; model[16] = 64'h5A;

    do_reset(8'h5A);
    // R1 reset values
    rd(32, v); check(v == BASE, "R1 trap base", v, BASE);
    rd(33, v); check(v == 64'h6, "R1 misc control", v, 64'h6);
    rd(16, v); check(v == 64'h5A, "R1 cpu id slot", v, 64'h5A);
    rd(0, v);  check(v == 64'h0, "R1 scratch zero", v, 64'h0);
    rd(45, v); check(v == 64'h0, "R1 masked zero", v, 64'h0);

    // R2 / R3 random writes with read-back
    for (int n = 0; n < 200; n++) begin
      int i;
      i = rwl[$urandom % 45];
      d = {$urandom, $urandom};
      wr(i, d, 1'b0);
      model[i] = exp_wr(i, d);
      rd(i, v);
      check(v == model[i], (i < 24 || i == 32 || i == 33) ? "R2 plain" : "R3 masked", v, model[i]);
    end
    for (int k = 0; k < 45; k++) begin
      rd(rwl[k], v);
      check(v == model[rwl[k]], "R2/R3 final sweep", v, model[rwl[k]]);
    end

    // R3 directed all ones
    wr(45, '1, 1'b0); rd(45, v);
    check(v == 64'h0000_00FF_FFFF_0300, "R3 insn ctl mask", v, 64'h0000_00FF_FFFF_0300);
    wr(52, '1, 1'b0); rd(52, v);
    check(v == 64'hFE00_0000_0000_0000, "R3 data asn mask", v, 64'hFE00_0000_0000_0000);
    // R4
    wr(37, '1, 1'b0); rd(37, v);
    check(v == ~64'h2, "R4 exc pc bit1", v, ~64'h2);
    // R5
    wr(43, '1, 1'b0); rd(43, v); check(v == 64'h0, "R5 exc sum clear", v, 64'h0);
    wr(44, 64'h55, 1'b0); rd(44, v); check(v == 64'h0, "R5 exc mask clear", v, 64'h0);

    // R6 cycle register
    wr(35, 64'hDEAD_BEEF_1234_5678, 1'b0);
    @(negedge clk); idx = 7'd35; rd_en = 1'b1;
    #1 a = rd_data;
    repeat (7) @(negedge clk);
    #1 b = rd_data;
    rd_en = 1'b0;
    check(a[63:32] == 32'hDEAD_BEEF, "R6 upper half", a, 64'hDEAD_BEEF);
    check(b[31:0] - a[31:0] == 32'd7, "R6 counter step", b[31:0] - a[31:0], 7);

    // R9 speculative writes
    rd(5, a);
    wr(5, ~a, 1'b1); rd(5, v);
    check(v == a, "R9 spec write ignored", v, a);
    wr(60, 64'h1, 1'b1);
    check(err == 1'b0, "R9 spec no error", err, 0);
    wr(84, 64'h0, 1'b1);
    check(fx_seen == 8'h0, "R9 spec no strobe", fx_seen, 0);

    // R11 strobes
    for (int k = 0; k < 8; k++) begin
      wr(fxi[k], 64'h1234, 1'b0);
      check(fx_seen == (8'h1 << k), "R11 strobe bit", fx_seen, 8'h1 << k);
    end
    wr(3, 64'h9, 1'b0);
    check(fx_seen == 8'h0, "R11 no strobe on plain", fx_seen, 0);
    rd(61, v); check(v == 64'h0, "R8 read-only reads 0", v, 0);
    check(err == 1'b0, "R8 legal accesses no error", err, 0);

    // R7 once rule
    wr(36, 64'h0, 1'b0);
    check(err == 1'b0, "R7 first write ok", err, 0);
    wr(36, 64'h0, 1'b0);
    check(err == 1'b1 && err_idx == 7'd36, "R7 second write error", {err, err_idx}, {1'b1, 7'd36});
    rd(70, v);
    check(err_idx == 7'd36, "R10 first index kept", err_idx, 36);

    do_reset(8'hC3);
    rd(16, v); check(v == 64'hC3, "R1 new cpu id", v, 64'hC3);
    rd(70, v);
    check(err == 1'b1 && err_idx == 7'd70, "R8 read write-only", {err, err_idx}, {1'b1, 7'd70});

    do_reset(8'h01);
    wr(61, 64'hFF, 1'b0);
    check(err == 1'b1 && err_idx == 7'd61, "R8 write read-only", {err, err_idx}, {1'b1, 7'd61});
    rd(61, v); check(v == 64'h0, "R10 read-only unchanged", v, 0);

    do_reset(8'h02);
    rd(100, v);
    check(err == 1'b1 && err_idx == 7'd100, "R8 undefined read", {err, err_idx}, {1'b1, 7'd100});

    do_reset(8'h03);
    wr(127, 64'h1, 1'b0);
    check(err == 1'b1 && err_idx == 7'd127, "R8 undefined write", {err, err_idx}, {1'b1, 7'd127});

    do_reset(8'h04);
    @(negedge clk); idx = 7'd84; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); fx_seen = side_fx; wr_en = 1'b0; rd_en = 1'b0;
    check(fx_seen == 8'h0, "R10 errored access no strobe", fx_seen, 0);
    check(err == 1'b1 && err_idx == 7'd84, "R10 error captured", {err, err_idx}, {1'b1, 7'd84});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule